// File: doc/BRIEF.md
# PLL Channel Control Register Bank with Bit-Operation Aliases

This block holds the control words for five clock-generator channels. Each channel word drives three things: a power-down line to its analog PLL, a bypass line, and a divider-select field. Software reaches each word through four addresses. One is a plain read/write view. The other three are write-only aliases that set, clear or invert only the bit positions written as 1. Software can therefore change one control bit without a read-modify-write sequence, and cannot race with other writers of the same word.

Out of reset every channel is powered down and bypassed, so downstream logic runs from the reference oscillator. For each channel the block also provides a filtered clock-select output that picks between the PLL output and the reference clock. This output takes the bypass value only after that value has been held for a programmable number of cycles. Short bypass pulses therefore never reach the clock multiplexer.

Top module: `pll_ctrl_bank`

## Requirements
- R1: After reset every channel word reads 0x0001_1000 (power-down bit 12 = 1, bypass bit 16 = 1, divider bits 6:0 = 0). pd_o, bypass_o and ref_sel_o are all ones and div_sel_o is zero.
- R2: A write to a channel's plain view (offset +0x0) replaces the writable bits (16, 12, 6:0) with the write data. All other bits always read 0.
- R3: A write to the set alias (offset +0x4) forces to 1 each writable bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A write to the clear alias (offset +0x8) forces to 0 each bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to the toggle alias (offset +0xC) inverts each writable bit written as 1 and leaves every bit written as 0 unchanged.
- R6: A read from any of the four views of a channel returns that channel's current word.
- R7: An access at a misaligned address (addr bits 1:0 not 0) or at or above NUM_CH*0x10 reads 0 and changes no channel.
- R8: Channel c sits at base c*0x10. A write to one channel leaves every other channel's word and outputs unchanged.
- R9: pd_o, bypass_o and div_sel_o change on the same clock edge that accepts the write.
- R10: ref_sel_o[c] takes the value of bypass_o[c] only after bypass_o[c] has differed from it for SETTLE_CYC consecutive edges (default 4). A bypass pulse that is shorter than this leaves ref_sel_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, accepted on the rising edge |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data or bit mask |
| rdata_o | output | 32 | Combinational read data for addr_i |
| pd_o | output | NUM_CH | Per-channel PLL power-down |
| bypass_o | output | NUM_CH | Per-channel bypass request |
| ref_sel_o | output | NUM_CH | Filtered select, 1 picks the reference clock |
| div_sel_o | output | NUM_CH*7 | Divider-select fields, channel 0 in the low bits |

## Verification
The bit operations are tried with several kinds of mask. All-ones masks show that reserved bits are dropped. Sparse masks that mix writable and reserved bits show that untouched positions are left alone. A zero mask on the clear alias must change nothing. Toggles that flip power-down and bypass in opposite directions rule out a set or clear being confused for a toggle. Writes spread over channels 0 to 4 separate correct channel decoding from aliasing between channels. Misaligned and out-of-range writes separate address qualification from plain channel selection. The select filter is tested with a one-cycle bypass pulse, which must be ignored, and with a held change, which is sampled one cycle before and one cycle after the settle count ends.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;

  localparam int DATA_W  = 32;
  localparam int PD_BIT  = 12;
  localparam int BYP_BIT = 16;
  localparam int DIV_W   = 7;

  localparam logic [DATA_W-1:0] DIV_MASK = DATA_W'((1 << DIV_W) - 1);
  localparam logic [DATA_W-1:0] WR_MASK  =
    DIV_MASK | (DATA_W'(1) << PD_BIT) | (DATA_W'(1) << BYP_BIT);
  localparam logic [DATA_W-1:0] RST_VAL  =
    (DATA_W'(1) << PD_BIT) | (DATA_W'(1) << BYP_BIT);

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } reg_op_e;

  function automatic logic [DATA_W-1:0] apply_op(
    input reg_op_e           op,
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] wd
  );
    logic [DATA_W-1:0] m;
    m = wd & WR_MASK;
    unique case (op)
      OP_WR:   apply_op = m;
      OP_SET:  apply_op = cur | m;
      OP_CLR:  apply_op = cur & ~m;
      OP_TOG:  apply_op = cur ^ m;
      default: apply_op = cur;
    endcase
  endfunction

endpackage

// File: rtl/pll_ctrl_dec.sv
module pll_ctrl_dec
  import pll_ctrl_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] hit_oh_o,
  output reg_op_e           op_o
);

  localparam int CH_W = ADDR_W - 4;

  logic            aligned;
  logic [CH_W-1:0] ch_field;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign ch_field = addr_i[ADDR_W-1:4];
  assign op_o     = reg_op_e'(addr_i[3:2]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    localparam logic [CH_W-1:0] CH_ID = CH_W'(c);
    assign hit_oh_o[c] = aligned && (ch_field == CH_ID);
  end

endmodule

// File: rtl/pll_chan_reg.sv
module pll_chan_reg
  import pll_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_op_e           op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] val_o,
  output logic              pd_o,
  output logic              byp_o,
  output logic [DIV_W-1:0]  div_o
);

  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= RST_VAL;
    else if (we_i) val_q <= apply_op(op_i, val_q, wdata_i);
  end

  assign val_o = val_q;
  assign pd_o  = val_q[PD_BIT];
  assign byp_o = val_q[BYP_BIT];
  assign div_o = val_q[DIV_W-1:0];

endmodule

// File: rtl/pll_sel_filter.sv
module pll_sel_filter #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic sel_o
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b1;
    end else if (req_i == sel_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      sel_q <= req_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/pll_ctrl_bank.sv
module pll_ctrl_bank
  import pll_ctrl_pkg::*;
#(
  parameter int NUM_CH     = 5,
  parameter int ADDR_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic [NUM_CH-1:0]       pd_o,
  output logic [NUM_CH-1:0]       bypass_o,
  output logic [NUM_CH-1:0]       ref_sel_o,
  output logic [NUM_CH*DIV_W-1:0] div_sel_o
);

  logic [NUM_CH-1:0] hit_oh;
  reg_op_e           op;
  logic [DATA_W-1:0] val [NUM_CH];

  pll_ctrl_dec #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_dec (
    .addr_i   (addr_i),
    .hit_oh_o (hit_oh),
    .op_o     (op)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pll_chan_reg u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && hit_oh[c]),
      .op_i    (op),
      .wdata_i (wdata_i),
      .val_o   (val[c]),
      .pd_o    (pd_o[c]),
      .byp_o   (bypass_o[c]),
      .div_o   (div_sel_o[c*DIV_W +: DIV_W])
    );

    pll_sel_filter #(
      .SETTLE_CYC (SETTLE_CYC)
    ) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (bypass_o[c]),
      .sel_o  (ref_sel_o[c])
    );
  end

  // one-hot OR mux; unmapped addresses give zero
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_oh[c]) rdata_o |= val[c];
    end
  end

endmodule

// File: rtl/pll_ctrl_bank_chk.sv
module pll_ctrl_bank_chk
  import pll_ctrl_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] pd_o,
  input logic [NUM_CH-1:0] bypass_o,
  input logic [NUM_CH-1:0] ref_sel_o
);

  localparam logic [ADDR_W:0] TOP_ADDR = (ADDR_W+1)'(NUM_CH * 16);

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~WR_MASK) == '0); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] != 2'b00 || {1'b0, addr_i} >= TOP_ADDR) |-> rdata_o == '0); // R7

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(c * 16 + 4);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(c * 16 + 8);
    localparam logic [ADDR_W-1:0] A_TOG = ADDR_W'(c * 16 + 12);
    localparam logic [ADDR_W-5:0] CH_ID = (ADDR_W-4)'(c);

    AST_SET_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == A_SET && wdata_i[PD_BIT] |=> pd_o[c]); // R3

    AST_CLR_BYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == A_CLR && wdata_i[BYP_BIT] |=> !bypass_o[c]); // R4

    AST_TOG_BYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == A_TOG && wdata_i[BYP_BIT]
      |=> bypass_o[c] != $past(bypass_o[c])); // R5

    AST_OTHER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && addr_i[1:0] == 2'b00 && addr_i[ADDR_W-1:4] == CH_ID)
      |=> $stable(pd_o[c]) && $stable(bypass_o[c])); // R8

    AST_SEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ref_sel_o[c]) |-> ref_sel_o[c] == $past(bypass_o[c])); // R10
  end

endmodule

bind pll_ctrl_bank pll_ctrl_bank_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pd_o      (pd_o),
  .bypass_o  (bypass_o),
  .ref_sel_o (ref_sel_o)
);

// File: tb/pll_ctrl_bank_test.sv
`timescale 1ns/1ps
module pll_ctrl_bank_test;

  localparam int NUM_CH = 5;
  localparam int ADDR_W = 8;
  localparam int NVEC   = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NUM_CH-1:0] pd_o, bypass_o, ref_sel_o;
  logic [NUM_CH*7-1:0] div_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  pll_ctrl_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SETTLE_CYC(4)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pd_o(pd_o), .bypass_o(bypass_o),
    .ref_sel_o(ref_sel_o), .div_sel_o(div_sel_o)
  );

  // {address, write data, expected channel word afterwards}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0001_107F},  // R2 plain write, reserved dropped
    {8'h08, 32'h0000_1005, 32'h0001_007A},  // R4 clear
    {8'h04, 32'h0000_0001, 32'h0001_007B},  // R3 set
    {8'h0C, 32'h0001_1003, 32'h0000_1078},  // R5 toggle
    {8'h14, 32'h0000_0010, 32'h0001_1010},  // R3 ch1
    {8'h18, 32'h0001_1000, 32'h0000_0010},  // R4 ch1
    {8'h4C, 32'hFFFF_FFFF, 32'h0000_007F},  // R5 ch4
    {8'h40, 32'h0001_0005, 32'h0001_0005},  // R2 ch4
    {8'h28, 32'h0000_0000, 32'h0001_1000},  // R4 zero mask
    {8'h3C, 32'h0000_1000, 32'h0001_0000}   // R5 ch3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int c = 0; c < NUM_CH; c++) begin
      rd(8'(c * 16), r);
      check("R1 reset word", r, 32'h0001_1000);
    end
    check("R1 pd_o", 32'(pd_o), 32'h1F);
    check("R1 bypass_o", 32'(bypass_o), 32'h1F);
    check("R1 ref_sel_o", 32'(ref_sel_o), 32'h1F);
    check("R1 div_sel_o", 32'(div_sel_o), 32'h0);

    // table walk: R2..R5, R9 via pd/bypass after the accepting edge
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]  a;
      logic [31:0] d, e;
      int ch;
      {a, d, e} = VEC[i];
      ch = int'(a[7:4]);
      wr(a, d);
      check("R9 pd_o after write", 32'(pd_o[ch]), 32'(e[12]));
      check("R9 bypass_o after write", 32'(bypass_o[ch]), 32'(e[16]));
      rd({a[7:4], 4'h0}, r);
      check($sformatf("R2-5 vector %0d", i), r, e);
    end

    // R6 alias reads
    rd(8'h04, r); check("R6 read via set alias", r, 32'h0000_1078);
    rd(8'h08, r); check("R6 read via clear alias", r, 32'h0000_1078);
    rd(8'h0C, r); check("R6 read via toggle alias", r, 32'h0000_1078);

    // R7 unmapped accesses
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h02, 32'h0000_0000);
    wr(8'h49, 32'hFFFF_FFFF);
    rd(8'h50, r); check("R7 out-of-range read", r, 32'h0);
    rd(8'h01, r); check("R7 misaligned read", r, 32'h0);
    rd(8'h00, r); check("R7 ch0 untouched", r, 32'h0000_1078);
    rd(8'h40, r); check("R7 ch4 untouched", r, 32'h0001_0005);
    check("R7 pd_o unchanged", 32'(pd_o), 32'b00101);
    check("R7 bypass_o unchanged", 32'(bypass_o), 32'b11100);

    // R8 per-channel final words
    rd(8'h10, r); check("R8 ch1", r, 32'h0000_0010);
    rd(8'h20, r); check("R8 ch2", r, 32'h0001_1000);
    rd(8'h30, r); check("R8 ch3", r, 32'h0001_0000);
    check("R8 ch4 div_sel", 32'(div_sel_o[34:28]), 32'd5);
    check("R8 ch0 div_sel", 32'(div_sel_o[6:0]), 32'h78);

    // R10 ch0 bypass cleared long ago
    check("R10 ch0 ref_sel settled", 32'(ref_sel_o[0]), 32'h0);

    // R9 same edge: ch2 power-down clear
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 8'h28; wdata_i = 32'h0000_1000;
    #1 check("R9 pd_o before edge", 32'(pd_o[2]), 32'h1);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R9 pd_o after edge", 32'(pd_o[2]), 32'h0);

    // R10 one-cycle bypass pulse on ch2 is filtered
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 8'h28; wdata_i = 32'h0001_0000;
    @(negedge clk_i);
    addr_i = 8'h24;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R10 bypass restored", 32'(bypass_o[2]), 32'h1);
    repeat (8) @(negedge clk_i);
    check("R10 pulse ignored", 32'(ref_sel_o[2]), 32'h1);

    // R10 held change: ref_sel moves on the 4th edge after the write edge
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 8'h28; wdata_i = 32'h0001_0000;
    @(negedge clk_i);            // after write edge
    wr_en_i = 1'b0;
    repeat (3) @(negedge clk_i); // after 3rd edge
    check("R10 before settle", 32'(ref_sel_o[2]), 32'h1);
    @(negedge clk_i);            // after 4th edge
    check("R10 after settle", 32'(ref_sel_o[2]), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule